// File: doc/BRIEF.md
# Dual-Set Pattern Bank Selector

This block maps the 8KB pattern window of a picture processor (addresses 0x0000 to 0x1FFF, thirteen address bits) onto a larger banked pattern memory. It works in units of 1KB. A host CPU writes twelve bank registers, a page-size mode and a two-bit upper-bit latch through a small register port. Every fetch address is turned into a pattern memory address in the same cycle, using purely combinational logic.

The bank registers form two sets. Set A is registers 0 to 7. Set B is registers 8 to 11, and it serves both 4KB halves of the window. The choice of set depends on four things: the sprite height flag, the current dot, whether rendering is enabled, and which set received the most recent bank write. A two-state machine holds that last piece of information. Its states are `TRK_SET_A`, which is also the reset state, and `TRK_SET_B`. There are two transitions. A bank write to registers 0 to 7 moves it to `TRK_SET_A`, and a bank write to registers 8 to 11 moves it to `TRK_SET_B`. Any other write leaves it in place.

Top module: `gfx_bank_sel`

## Requirements
- R1: After reset, all bank registers, the upper latch and the mode are zero, and the tracker is in `TRK_SET_A`. In that state `pat_addr` equals `ppu_addr` zero-extended.
- R2: A bank write stores `{upper latch, wr_data}` as a 10-bit bank value. A later change to the upper latch does not alter a value that is already stored.
- R3: Mode encoding on `wr_data[1:0]` of a mode write is as follows. 0 gives one 8KB page, 1 gives two 4KB pages, 2 gives four 2KB pages and 3 gives eight 1KB pages. The page number is (bank << (3 − mode)) OR (the low 3 − mode bits of `ppu_addr[12:10]`).
- R4: The set A register index is `ppu_addr[12:10]` with its low 3 − mode bits forced to 1. This gives 7 in mode 0, 3 or 7 in mode 1, 1/3/5/7 in mode 2 and 0 to 7 in mode 3.
- R5: The set B register index is 8 plus the low two bits of the set A index. This gives 11 in modes 0 and 1, 9 or 11 in mode 2, and 8 to 11 repeated in mode 3.
- R6: When rendering is on and `tall_spr` = 1, set A is used for dots 257 to 320 inclusive and set B is used at every other dot.
- R7: When rendering is on and `tall_spr` = 0, the set named by the tracker is used. Only bank writes change the tracker.
- R8: When `bg_en` = 0 and `spr_en` = 0, set A is used regardless of the other inputs.
- R9: The register select `wr_sel` is decoded as follows. 0x00 to 0x0B are bank registers 0 to 11. 0x10 is the mode register (bits 1:0). 0x11 is the upper latch (bits 1:0). Any other select, and any cycle with `wr_en` = 0, changes nothing.
- R10: `pat_addr` = {page number (13 bits), `ppu_addr[9:0]`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 5 | Register select |
| wr_data | input | 8 | Register write data |
| bg_en | input | 1 | Background rendering enabled |
| spr_en | input | 1 | Sprite rendering enabled |
| tall_spr | input | 1 | Sprites are 8x16 |
| dot | input | 9 | Current dot within the scanline |
| ppu_addr | input | 13 | Pattern fetch address |
| pat_addr | output | 23 | Banked pattern memory address |

## Verification
The hardest situation to reach is one where the tracker disagrees with the set actually in use. This happens when tall sprites or disabled rendering override a tracker that points at set B. It also happens when a non-bank write, such as a mode or latch write, follows a set B bank write. The stimulus table reaches these cases by rewriting a chosen bank register, with its known value, just before each vector. This positions the tracker without disturbing the bank contents. Dot values on both sides of 257 and 320 then probe the window edges.

// File: rtl/gfx_bank_pkg.sv
package gfx_bank_pkg;
    localparam int NUM_BANKS  = 12;
    localparam int SET_A_REGS = 8;
    localparam int DATA_W     = 8;
    localparam int UPPER_W    = 2;
    localparam int BANK_W     = DATA_W + UPPER_W;
    localparam int SLOT_W     = 3;
    localparam int OFF_W      = 10;
    localparam int PA_W       = SLOT_W + OFF_W;
    localparam int PAGE_W     = BANK_W + SLOT_W;
    localparam int OUT_W      = PAGE_W + OFF_W;
    localparam int SEL_W      = 5;
    localparam int IDX_W      = 4;
    localparam logic [SEL_W-1:0] SEL_MODE  = 5'h10;
    localparam logic [SEL_W-1:0] SEL_UPPER = 5'h11;

    typedef enum logic [1:0] {
        MODE_8K = 2'd0,
        MODE_4K = 2'd1,
        MODE_2K = 2'd2,
        MODE_1K = 2'd3
    } page_mode_e;

    typedef enum logic {
        TRK_SET_A = 1'b0,
        TRK_SET_B = 1'b1
    } trk_state_e;

    typedef logic [NUM_BANKS-1:0][BANK_W-1:0] bank_arr_t;
endpackage

// File: rtl/gfx_bank_regfile.sv
module gfx_bank_regfile
    import gfx_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    output bank_arr_t          banks,
    output page_mode_e         mode,
    output logic               bank_wr,
    output logic               bank_hi
);
    logic [UPPER_W-1:0] upper_q;
    page_mode_e         mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            mode_q  <= MODE_8K;
        end else if (wr_en) begin
            if (wr_sel == SEL_UPPER) upper_q <= wr_data[UPPER_W-1:0];
            if (wr_sel == SEL_MODE)  mode_q  <= page_mode_e'(wr_data[1:0]);
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [BANK_W-1:0] bank_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank_q <= '0;
            else if (wr_en && wr_sel == SEL_W'(g))
                bank_q <= {upper_q, wr_data};
        end
        assign banks[g] = bank_q;
    end

    assign mode    = mode_q;
    assign bank_wr = wr_en && (wr_sel < SEL_W'(NUM_BANKS));
    assign bank_hi = wr_sel >= SEL_W'(SET_A_REGS);
endmodule

// File: rtl/gfx_bank_track.sv
module gfx_bank_track
    import gfx_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bank_wr,
    input  logic bank_hi,
    output logic last_a
);
    trk_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRK_SET_A;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        last_a  = 1'b1;
        unique case (state_q)
            TRK_SET_A: begin
                last_a = 1'b1;
                if (bank_wr && bank_hi) state_d = TRK_SET_B;
            end
            TRK_SET_B: begin
                last_a = 1'b0;
                if (bank_wr && !bank_hi) state_d = TRK_SET_A;
            end
        endcase
    end
endmodule

// File: rtl/gfx_bank_setsel.sv
module gfx_bank_setsel #(
    parameter int DOT_W     = 9,
    parameter int SPR_FIRST = 257,
    parameter int SPR_LAST  = 320
) (
    input  logic             bg_en,
    input  logic             spr_en,
    input  logic             tall_spr,
    input  logic [DOT_W-1:0] dot,
    input  logic             last_a,
    output logic             use_a
);
    logic in_window;
    logic rendering;

    assign in_window = (dot >= DOT_W'(SPR_FIRST)) && (dot <= DOT_W'(SPR_LAST));
    assign rendering = bg_en || spr_en;

    always_comb begin
        if (!rendering)    use_a = 1'b1;
        else if (tall_spr) use_a = in_window;
        else               use_a = last_a;
    end
endmodule

// File: rtl/gfx_bank_pagemap.sv
module gfx_bank_pagemap
    import gfx_bank_pkg::*;
(
    input  bank_arr_t         banks,
    input  page_mode_e        mode,
    input  logic              use_a,
    input  logic [PA_W-1:0]   ppu_addr,
    output logic [OUT_W-1:0]  pat_addr
);
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] low_mask;
    logic [SLOT_W-1:0] idx_a;
    logic [IDX_W-1:0]  idx;
    logic [BANK_W-1:0] bank;
    logic [PAGE_W-1:0] page;

    assign slot = ppu_addr[PA_W-1:OFF_W];

    always_comb begin
        unique case (mode)
            MODE_8K: low_mask = 3'b111;
            MODE_4K: low_mask = 3'b011;
            MODE_2K: low_mask = 3'b001;
            MODE_1K: low_mask = 3'b000;
        endcase
    end

    assign idx_a = slot | low_mask;
    assign idx   = use_a ? {1'b0, idx_a} : {2'b10, idx_a[1:0]};

    always_comb begin
        bank = '0;
        for (int i = 0; i < NUM_BANKS; i++)
            if (idx == IDX_W'(i)) bank = banks[i];
    end

    always_comb begin
        unique case (mode)
            MODE_8K: page = {bank, 3'b000};
            MODE_4K: page = {1'b0, bank, 2'b00};
            MODE_2K: page = {2'b00, bank, 1'b0};
            MODE_1K: page = {3'b000, bank};
        endcase
        page = page | PAGE_W'(slot & low_mask);
    end

    assign pat_addr = {page, ppu_addr[OFF_W-1:0]};
endmodule

// File: rtl/gfx_bank_sel.sv
module gfx_bank_sel
    import gfx_bank_pkg::*;
#(
    parameter int DOT_W     = 9,
    parameter int SPR_FIRST = 257,
    parameter int SPR_LAST  = 320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        wr_sel,
    input  logic [7:0]        wr_data,
    input  logic              bg_en,
    input  logic              spr_en,
    input  logic              tall_spr,
    input  logic [DOT_W-1:0]  dot,
    input  logic [12:0]       ppu_addr,
    output logic [22:0]       pat_addr
);
    bank_arr_t  banks;
    page_mode_e mode_q;
    logic       bank_wr;
    logic       bank_hi;
    logic       last_a;
    logic       use_a;

    gfx_bank_regfile i_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .banks   (banks),
        .mode    (mode_q),
        .bank_wr (bank_wr),
        .bank_hi (bank_hi)
    );

    gfx_bank_track i_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank_wr (bank_wr),
        .bank_hi (bank_hi),
        .last_a  (last_a)
    );

    gfx_bank_setsel #(
        .DOT_W     (DOT_W),
        .SPR_FIRST (SPR_FIRST),
        .SPR_LAST  (SPR_LAST)
    ) i_setsel (
        .bg_en    (bg_en),
        .spr_en   (spr_en),
        .tall_spr (tall_spr),
        .dot      (dot),
        .last_a   (last_a),
        .use_a    (use_a)
    );

    gfx_bank_pagemap i_pagemap (
        .banks    (banks),
        .mode     (mode_q),
        .use_a    (use_a),
        .ppu_addr (ppu_addr),
        .pat_addr (pat_addr)
    );
endmodule

// File: rtl/gfx_bank_sel_chk.sv
module gfx_bank_sel_chk #(
    parameter int DOT_W     = 9,
    parameter int SPR_FIRST = 257,
    parameter int SPR_LAST  = 320
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [4:0]       wr_sel,
    input logic             bg_en,
    input logic             spr_en,
    input logic             tall_spr,
    input logic [DOT_W-1:0] dot,
    input logic [12:0]      ppu_addr,
    input logic [22:0]      pat_addr,
    input logic [1:0]       mode,
    input logic             last_a,
    input logic             use_a
);
    logic in_win;
    assign in_win = (dot >= DOT_W'(SPR_FIRST)) && (dot <= DOT_W'(SPR_LAST));

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        pat_addr[9:0] == ppu_addr[9:0]); // R10
    AST_PAGE8K_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'd0 |-> pat_addr[12:10] == ppu_addr[12:10]); // R3
    AST_PAGE4K_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'd1 |-> pat_addr[11:10] == ppu_addr[11:10]); // R3
    AST_TRACK_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel < 5'd8 |=> last_a); // R7
    AST_TRACK_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel >= 5'd8 && wr_sel < 5'd12 |=> !last_a); // R7
    AST_TRACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel < 5'd12) |=> $stable(last_a)); // R9
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 5'h10) |=> $stable(mode)); // R9
    AST_IDLE_SET_A: assert property (@(posedge clk) disable iff (!rst_n)
        !bg_en && !spr_en |-> use_a); // R8
    AST_TALL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bg_en || spr_en) && tall_spr |-> use_a == in_win); // R6
    AST_SHORT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bg_en || spr_en) && !tall_spr |-> use_a == last_a); // R7
endmodule

bind gfx_bank_sel gfx_bank_sel_chk #(
    .DOT_W     (DOT_W),
    .SPR_FIRST (SPR_FIRST),
    .SPR_LAST  (SPR_LAST)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .bg_en    (bg_en),
    .spr_en   (spr_en),
    .tall_spr (tall_spr),
    .dot      (dot),
    .ppu_addr (ppu_addr),
    .pat_addr (pat_addr),
    .mode     (mode_q),
    .last_a   (last_a),
    .use_a    (use_a)
);

// File: tb/test_gfx_bank_sel.sv
module test_gfx_bank_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        bg_en = 1'b0;
    logic        spr_en = 1'b0;
    logic        tall_spr = 1'b0;
    logic [8:0]  dot = '0;
    logic [12:0] ppu_addr = '0;
    logic [22:0] pat_addr;

    int checks = 0;
    int failures = 0;
    logic [9:0] bank_m [12];

    always #5 clk = ~clk;

    gfx_bank_sel i_gfx_bank_sel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .bg_en(bg_en), .spr_en(spr_en),
        .tall_spr(tall_spr), .dot(dot), .ppu_addr(ppu_addr),
        .pat_addr(pat_addr)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic       tall;
        logic [1:0] ren;
        logic [8:0] dot;
        logic [2:0] slot;
        logic [3:0] touch;
        logic [3:0] idx;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 2'b11, 9'd10,  3'd5, 4'd2,  4'd7},  // R4 mode0 A
        '{2'd0, 1'b0, 2'b11, 9'd10,  3'd5, 4'd9,  4'd11}, // R5 mode0 B
        '{2'd1, 1'b0, 2'b11, 9'd10,  3'd1, 4'd0,  4'd3},  // R4
        '{2'd1, 1'b0, 2'b11, 9'd10,  3'd6, 4'd0,  4'd7},  // R4
        '{2'd1, 1'b0, 2'b11, 9'd10,  3'd6, 4'd10, 4'd11}, // R5
        '{2'd2, 1'b0, 2'b11, 9'd10,  3'd2, 4'd7,  4'd3},  // R4
        '{2'd2, 1'b0, 2'b11, 9'd10,  3'd4, 4'd8,  4'd9},  // R5
        '{2'd3, 1'b0, 2'b11, 9'd10,  3'd6, 4'd1,  4'd6},  // R4
        '{2'd3, 1'b0, 2'b11, 9'd10,  3'd6, 4'd11, 4'd10}, // R5
        '{2'd3, 1'b0, 2'b11, 9'd10,  3'd5, 4'd11, 4'd9},  // R5
        '{2'd3, 1'b1, 2'b11, 9'd257, 3'd4, 4'd11, 4'd4},  // R6 first dot
        '{2'd3, 1'b1, 2'b11, 9'd320, 3'd3, 4'd11, 4'd3},  // R6 last dot
        '{2'd3, 1'b1, 2'b11, 9'd256, 3'd3, 4'd0,  4'd11}, // R6 before
        '{2'd3, 1'b1, 2'b11, 9'd321, 3'd0, 4'd0,  4'd8},  // R6 after
        '{2'd3, 1'b0, 2'b00, 9'd10,  3'd6, 4'd11, 4'd6},  // R8
        '{2'd3, 1'b1, 2'b00, 9'd100, 3'd2, 4'd11, 4'd2},  // R8
        '{2'd3, 1'b0, 2'b01, 9'd10,  3'd1, 4'd11, 4'd9},  // R7 sprites only
        '{2'd2, 1'b0, 2'b10, 9'd10,  3'd7, 4'd3,  4'd7}   // R7 background only
    };

    task automatic wr(input logic [4:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wbank(input int i, input logic [1:0] up, input logic [7:0] d);
        wr(5'h11, {6'b0, up});
        wr(5'(i), d);
        bank_m[i] = {up, d};
    endtask

    function automatic logic [22:0] expect_addr(input logic [1:0] m, input logic [3:0] idx,
                                                input logic [12:0] pa);
        logic [12:0] page;
        logic [2:0]  mask;
        int sh;
        sh   = 3 - int'(m);
        mask = 3'((1 << sh) - 1);
        page = (13'(bank_m[idx]) << sh) | 13'(pa[12:10] & mask);
        return {page, pa[9:0]};
    endfunction

    task automatic check(input string req, input logic [22:0] exp);
        #1;
        checks++;
        if (pat_addr !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, pat_addr, exp);
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 12; i++) bank_m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, mode 0 with zero banks passes address through
        bg_en = 1'b1; spr_en = 1'b1; ppu_addr = 13'h1ABC;
        check("R1", 23'h001ABC);
        bg_en = 1'b0; spr_en = 1'b0; tall_spr = 1'b1; dot = 9'd300;
        check("R1", 23'h001ABC);

        for (int i = 0; i < 12; i++) wbank(i, 2'(i), 8'(8'h40 + 7 * i));

        // table walk: R3 R4 R5 R6 R7 R8 R10
        for (int v = 0; v < NV; v++) begin
            wr(5'h10, {6'b0, VECS[v].mode});
            wbank(int'(VECS[v].touch), 2'(VECS[v].touch), 8'(8'h40 + 7 * VECS[v].touch));
            tall_spr = VECS[v].tall;
            bg_en    = VECS[v].ren[1];
            spr_en   = VECS[v].ren[0];
            dot      = VECS[v].dot;
            ppu_addr = {VECS[v].slot, 10'(10'h155 + v)};
            check("R3/R10 table", expect_addr(VECS[v].mode, VECS[v].idx, ppu_addr));
        end

        // R2: upper latch captured at write time only
        wbank(0, 2'd1, 8'h5A);
        wr(5'h11, 8'h02);
        wr(5'h10, 8'h03);
        tall_spr = 1'b0; bg_en = 1'b1; spr_en = 1'b1; dot = 9'd10;
        ppu_addr = 13'h0033;
        check("R2", {13'h015A, 10'h033});

        // R9: unmapped select and idle strobe change nothing
        wr(5'h0C, 8'hFF);
        wr(5'h1F, 8'h00);
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 5'h10; wr_data = 8'h00;
        @(negedge clk);
        ppu_addr = 13'h0033;
        check("R9", {13'h015A, 10'h033});
        ppu_addr = 13'h0477;
        check("R9", expect_addr(2'd3, 4'd1, 13'h0477));

        // R7: mode/latch writes do not move the tracker off set B
        wbank(11, 2'd2, 8'hC3);
        wr(5'h10, 8'h03);
        wr(5'h11, 8'h00);
        ppu_addr = 13'h0B01;
        check("R7", expect_addr(2'd3, 4'd10, 13'h0B01));
        ppu_addr = 13'h1F02;
        check("R7", expect_addr(2'd3, 4'd11, 13'h1F02));
        // R5 mode1 with set B after rewriting reg 11
        wr(5'h10, 8'h01);
        ppu_addr = 13'h0404;
        check("R5", expect_addr(2'd1, 4'd11, 13'h0404));

        // R1: reset returns to set A and zero banks
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) bank_m[i] = '0;
        ppu_addr = 13'h1555;
        check("R1", 23'h001555);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule